// File: doc/BRIEF.md
# Region-Based Memory Access Checker

This block sits in the path between a bus master and memory and decides, for every access, whether it may proceed. Software programs up to eight protection regions. Each region has a base address, a power-of-two size, a byte that can knock out any of its eight equal slices, and four permission bits. For each access the block presents the address, a write flag and a privilege flag. A combinational allow signal answers in the same cycle.

A denied access raises a one-cycle fault pulse on the next cycle. The address, direction and privilege of the first denied access are latched and held until software clears them. A global enable, which is off after reset, lets the whole unit be bypassed. Region settings may be rewritten at any time, for example on a task switch. A write affects accesses from the following cycle on.

Top module: `region_guard`

## Requirements
- R1: After reset the unit is disabled, every region is disabled, `faultValid` and `faultPulse` are 0, and `accAllow` is 1.
- R2: While the unit is disabled (`enVal` last written as 0), `accAllow` is 1 for every access and no fault is raised.
- R3: A region matches when the address bits at and above position `sizeLog2` equal the same bits of its base. Base bits below `sizeLog2` are ignored. A written `sizeLog2` below 5 is stored as 5, and one above 32 is stored as 32; size 32 covers the whole 4 GB space.
- R4: Slice index = address bits [`sizeLog2`-1 : `sizeLog2`-3]. If bit k of `cfgSliceOff` is set, addresses in slice k do not match that region.
- R5: The permission bits are: bit 0 privileged read, bit 1 privileged write, bit 2 unprivileged read, bit 3 unprivileged write. A matched access is allowed only when its bit is 1.
- R6: When several enabled regions match, the highest-numbered one alone supplies the permission.
- R7: With the unit enabled, an access that matches no enabled region is allowed when privileged and denied when unprivileged.
- R8: `faultPulse` is 1 for exactly the cycle after each cycle in which `accValid` is 1 and `accAllow` is 0. A denial with `accValid` at 0 raises nothing.
- R9: When no fault is held, a denied access sets `faultValid` on the next cycle and latches its address, write flag and privilege. Later denials do not overwrite the held values.
- R10: `faultClr` clears `faultValid` on the next cycle. A denied access in the same cycle as `faultClr` is captured as a new fault.
- R11: A configuration write takes effect for accesses in the cycle after `cfgWe`. An access in the same cycle still sees the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enWe | input | 1 | Write strobe for the global enable |
| enVal | input | 1 | Global enable value |
| cfgWe | input | 1 | Region write strobe |
| cfgIdx | input | 3 | Region number to write |
| cfgOn | input | 1 | Region enable |
| cfgBase | input | 32 | Region base address |
| cfgSizeLog2 | input | 6 | log2 of region size |
| cfgSliceOff | input | 8 | Per-slice exclusion bits |
| cfgPerm | input | 4 | Permission bits |
| accValid | input | 1 | Access present |
| accAddr | input | 32 | Access address |
| accWrite | input | 1 | 1 = write, 0 = read |
| accPriv | input | 1 | 1 = privileged |
| accAllow | output | 1 | Access permitted (combinational) |
| faultClr | input | 1 | Clear held fault |
| faultPulse | output | 1 | One-cycle denial pulse |
| faultValid | output | 1 | A fault is held |
| faultAddr | output | 32 | Captured fault address |
| faultWrite | output | 1 | Captured write flag |
| faultPriv | output | 1 | Captured privilege |

## Verification
The hardest case to reach from the ports is a denial that arrives in the same cycle as `faultClr` while an older fault is still held. Three events have to line up: the clear, the new denial, and the old capture. The directed task first creates a held fault. It then asserts `faultClr` together with an unprivileged access to an unmatched address, and checks that the new address replaces the old one. Overlapping regions get the same treatment: the bench programs them so that the highest-numbered region alternately grants and refuses, which shows the priority decides the result rather than any match.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;
  parameter int RG_ADDR_W = 32;
  parameter int RG_SLICES = 8;
  parameter int RG_MIN_LOG2 = 5;
  localparam int RG_SLICE_W = $clog2(RG_SLICES);
  localparam int RG_SZ_W = $clog2(RG_ADDR_W + 1);

  typedef struct packed {
    logic                   on;
    logic [RG_SZ_W-1:0]     sizeLog2;
    logic [RG_ADDR_W-1:0]   base;
    logic [RG_SLICES-1:0]   sliceOff;
    logic [3:0]             perm;
  } region_t;

  typedef struct packed {
    logic cfgLoad;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/region_guard_dp.sv
module region_guard_dp
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [IDX_W-1:0]     cfgIdx,
  input  logic                 cfgOn,
  input  logic [RG_ADDR_W-1:0] cfgBase,
  input  logic [5:0]           cfgSizeLog2,
  input  logic [RG_SLICES-1:0] cfgSliceOff,
  input  logic [3:0]           cfgPerm,
  input  logic [RG_ADDR_W-1:0] accAddr,
  input  logic                 accWrite,
  input  logic                 accPriv,
  output logic                 hitAny,
  output logic [3:0]           hitPerm,
  output logic [RG_ADDR_W-1:0] faultAddr,
  output logic                 faultWrite,
  output logic                 faultPriv
);
  localparam logic [5:0] MIN_SZ = 6'(RG_MIN_LOG2);
  localparam logic [5:0] MAX_SZ = 6'(RG_ADDR_W);

  region_t regs [NUM_REGIONS];
  region_t newRegion;
  logic [NUM_REGIONS-1:0] hitVec;

  always_comb begin
    newRegion.on       = cfgOn;
    newRegion.base     = cfgBase;
    newRegion.sliceOff = cfgSliceOff;
    newRegion.perm     = cfgPerm;
    if (cfgSizeLog2 < MIN_SZ)      newRegion.sizeLog2 = RG_SZ_W'(MIN_SZ);
    else if (cfgSizeLog2 > MAX_SZ) newRegion.sizeLog2 = RG_SZ_W'(MAX_SZ);
    else                           newRegion.sizeLog2 = RG_SZ_W'(cfgSizeLog2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        regs[i] <= '{on: 1'b0, sizeLog2: RG_SZ_W'(MIN_SZ), base: '0, sliceOff: '0, perm: '0};
      end
    end else if (stb.cfgLoad) begin
      regs[cfgIdx] <= newRegion;
    end
  end

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : gMatch
    logic [RG_ADDR_W-1:0]  hiMask;
    logic [RG_SLICE_W-1:0] sliceIdx;
    always_comb begin
      hiMask   = ~RG_ADDR_W'(({{RG_ADDR_W{1'b0}}, 1'b1} << regs[r].sizeLog2) - 1'b1);
      sliceIdx = RG_SLICE_W'(accAddr >> (regs[r].sizeLog2 - RG_SZ_W'(RG_SLICE_W)));
      hitVec[r] = regs[r].on && (((accAddr ^ regs[r].base) & hiMask) == '0)
                  && !regs[r].sliceOff[sliceIdx];
    end
  end

  always_comb begin
    hitAny  = 1'b0;
    hitPerm = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (hitVec[r]) begin
        hitAny  = 1'b1;
        hitPerm = regs[r].perm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultAddr  <= '0;
      faultWrite <= 1'b0;
      faultPriv  <= 1'b0;
    end else if (stb.capture) begin
      faultAddr  <= accAddr;
      faultWrite <= accWrite;
      faultPriv  <= accPriv;
    end
  end
endmodule

// File: rtl/region_guard_ctrl.sv
module region_guard_ctrl
  import region_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enWe,
  input  logic       enVal,
  input  logic       cfgWe,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic       accPriv,
  input  logic       hitAny,
  input  logic [3:0] hitPerm,
  input  logic       faultClr,
  output strobe_t    stb,
  output logic       unitEn,
  output logic       accAllow,
  output logic       faultPulse,
  output logic       faultValid
);
  logic permOk;
  logic deny;
  logic heldAfterClr;

  always_comb begin
    permOk       = hitAny ? hitPerm[{~accPriv, accWrite}] : accPriv;
    accAllow     = !unitEn || permOk;
    deny         = accValid && !accAllow;
    heldAfterClr = faultValid && !faultClr;
    stb.cfgLoad  = cfgWe;
    stb.capture  = deny && !heldAfterClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unitEn     <= 1'b0;
      faultPulse <= 1'b0;
      faultValid <= 1'b0;
    end else begin
      if (enWe) unitEn <= enVal;
      faultPulse <= deny;
      faultValid <= heldAfterClr || stb.capture;
    end
  end
endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int IDX_W = $clog2(NUM_REGIONS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enWe,
  input  logic                 enVal,
  input  logic                 cfgWe,
  input  logic [IDX_W-1:0]     cfgIdx,
  input  logic                 cfgOn,
  input  logic [RG_ADDR_W-1:0] cfgBase,
  input  logic [5:0]           cfgSizeLog2,
  input  logic [RG_SLICES-1:0] cfgSliceOff,
  input  logic [3:0]           cfgPerm,
  input  logic                 accValid,
  input  logic [RG_ADDR_W-1:0] accAddr,
  input  logic                 accWrite,
  input  logic                 accPriv,
  output logic                 accAllow,
  input  logic                 faultClr,
  output logic                 faultPulse,
  output logic                 faultValid,
  output logic [RG_ADDR_W-1:0] faultAddr,
  output logic                 faultWrite,
  output logic                 faultPriv
);
  strobe_t    stb;
  logic       unitEn;
  logic       hitAny;
  logic [3:0] hitPerm;

  region_guard_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enWe(enWe), .enVal(enVal), .cfgWe(cfgWe),
    .accValid(accValid), .accWrite(accWrite), .accPriv(accPriv),
    .hitAny(hitAny), .hitPerm(hitPerm), .faultClr(faultClr),
    .stb(stb), .unitEn(unitEn), .accAllow(accAllow),
    .faultPulse(faultPulse), .faultValid(faultValid)
  );

  region_guard_dp #(.NUM_REGIONS(NUM_REGIONS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgIdx(cfgIdx), .cfgOn(cfgOn),
    .cfgBase(cfgBase), .cfgSizeLog2(cfgSizeLog2), .cfgSliceOff(cfgSliceOff),
    .cfgPerm(cfgPerm), .accAddr(accAddr), .accWrite(accWrite), .accPriv(accPriv),
    .hitAny(hitAny), .hitPerm(hitPerm), .faultAddr(faultAddr),
    .faultWrite(faultWrite), .faultPriv(faultPriv)
  );
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk (
  input logic        clk,
  input logic        rstN,
  input logic        unitEn,
  input logic        accValid,
  input logic [31:0] accAddr,
  input logic        accAllow,
  input logic        faultClr,
  input logic        faultPulse,
  input logic        faultValid,
  input logic [31:0] faultAddr
);
  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rstN)
    !unitEn |-> accAllow);

  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accAllow) |=> faultPulse);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(accValid && !accAllow) |=> !faultPulse);

  assert_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!faultValid && accValid && !accAllow) |=> (faultValid && faultAddr == $past(accAddr)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !faultClr) |=> (faultValid && $stable(faultAddr)));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (faultClr && !(accValid && !accAllow)) |=> !faultValid);
endmodule

bind region_guard region_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .unitEn(unitEn), .accValid(accValid), .accAddr(accAddr),
  .accAllow(accAllow), .faultClr(faultClr), .faultPulse(faultPulse),
  .faultValid(faultValid), .faultAddr(faultAddr)
);

// File: tb/region_guard_tb.sv
`timescale 1ns/1ps
module region_guard_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic enWe = 0, enVal = 0, cfgWe = 0, cfgOn = 0;
  logic [2:0] cfgIdx = 0;
  logic [31:0] cfgBase = 0;
  logic [5:0] cfgSizeLog2 = 0;
  logic [7:0] cfgSliceOff = 0;
  logic [3:0] cfgPerm = 0;
  logic accValid = 0, accWrite = 0, accPriv = 0, faultClr = 0;
  logic [31:0] accAddr = 0;
  logic accAllow, faultPulse, faultValid, faultWrite, faultPriv;
  logic [31:0] faultAddr;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  region_guard u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic setRegion(input int idx, input logic on, input logic [31:0] base,
                           input logic [5:0] sz, input logic [7:0] off, input logic [3:0] perm);
    cfgWe = 1; cfgIdx = 3'(idx); cfgOn = on; cfgBase = base;
    cfgSizeLog2 = sz; cfgSliceOff = off; cfgPerm = perm;
    tick();
    cfgWe = 0;
  endtask

  task automatic setEnable(input logic v);
    enWe = 1; enVal = v; tick(); enWe = 0;
  endtask

  task automatic clearFault();
    faultClr = 1; tick(); faultClr = 0;
  endtask

  // one access: check combinational decision, then the pulse a cycle later
  task automatic probe(input logic [31:0] a, input logic wr, input logic pr,
                       input logic expAllow, input string tag);
    accValid = 1; accAddr = a; accWrite = wr; accPriv = pr;
    #1 chk({tag, " allow"}, 32'(accAllow), 32'(expAllow));
    tick();
    accValid = 0;
    chk({tag, " pulse"}, 32'(faultPulse), 32'(!expAllow));
  endtask

  task automatic t_reset();
    chk("R1 faultValid", 32'(faultValid), 0);
    chk("R1 faultPulse", 32'(faultPulse), 0);
    accAddr = 32'h1234_5678; accWrite = 1; accPriv = 0;
    #1 chk("R1 allow", 32'(accAllow), 1);
  endtask

  task automatic t_bypass();
    probe(32'hDEAD_BEE0, 1, 0, 1, "R2 unpriv write bypassed");
    chk("R2 no fault held", 32'(faultValid), 0);
  endtask

  task automatic t_nomatch_and_fault();
    setEnable(1);
    probe(32'h0000_1000, 0, 1, 1, "R7 priv no-match");
    probe(32'h0000_2000, 1, 0, 0, "R7 unpriv no-match");
    chk("R9 valid", 32'(faultValid), 1);
    chk("R9 addr", faultAddr, 32'h0000_2000);
    chk("R9 write", 32'(faultWrite), 1);
    chk("R9 priv", 32'(faultPriv), 0);
    probe(32'h0000_3000, 0, 0, 0, "R9 second denial");
    chk("R9 addr held", faultAddr, 32'h0000_2000);
    chk("R9 write held", 32'(faultWrite), 1);
    // invalid access produces nothing
    accValid = 0; accAddr = 32'h0000_4000; accPriv = 0; tick();
    chk("R8 invalid no pulse", 32'(faultPulse), 0);
    clearFault();
    chk("R10 cleared", 32'(faultValid), 0);
  endtask

  task automatic t_clear_race();
    probe(32'h0000_5000, 0, 0, 0, "R10 setup");
    chk("R10 setup held", faultAddr, 32'h0000_5000);
    faultClr = 1; accValid = 1; accAddr = 32'h0000_6000; accWrite = 0; accPriv = 0;
    tick();
    faultClr = 0; accValid = 0;
    chk("R10 race valid", 32'(faultValid), 1);
    chk("R10 race addr", faultAddr, 32'h0000_6000);
    clearFault();
  endtask

  task automatic t_size();
    setRegion(0, 1, 32'h2000_0123, 6'd12, 8'h00, 4'hF);
    probe(32'h2000_0000, 0, 0, 1, "R3 base low bits ignored");
    probe(32'h2000_0FFC, 1, 0, 1, "R3 top of 4KB");
    probe(32'h2000_1000, 0, 0, 0, "R3 just past 4KB");
    setRegion(0, 1, 32'h2000_0000, 6'd2, 8'h00, 4'hF);
    probe(32'h2000_001F, 0, 0, 1, "R3 clamp to 32B inside");
    probe(32'h2000_0020, 0, 0, 0, "R3 clamp to 32B outside");
    setRegion(0, 1, 32'h0, 6'd40, 8'h00, 4'hF);
    probe(32'hF000_0000, 1, 0, 1, "R3 whole space");
    setRegion(0, 1, 32'h2000_0000, 6'd12, 8'h00, 4'hF);
    clearFault();
  endtask

  task automatic t_slice();
    setRegion(1, 1, 32'h4000_0000, 6'd16, 8'b0000_0100, 4'hF);
    probe(32'h4000_3FFC, 0, 0, 1, "R4 slice1 kept");
    probe(32'h4000_4000, 0, 0, 0, "R4 slice2 excluded");
    probe(32'h4000_5FFC, 1, 0, 0, "R4 slice2 end excluded");
    probe(32'h4000_6000, 0, 0, 1, "R4 slice3 kept");
    clearFault();
  endtask

  task automatic t_perm_prio();
    setRegion(2, 1, 32'h8000_0000, 6'd10, 8'h00, 4'b0101);
    probe(32'h8000_0100, 0, 1, 1, "R5 priv read");
    probe(32'h8000_0100, 1, 1, 0, "R5 priv write");
    probe(32'h8000_0100, 0, 0, 1, "R5 unpriv read");
    probe(32'h8000_0100, 1, 0, 0, "R5 unpriv write");
    setRegion(3, 1, 32'h8000_0000, 6'd8, 8'h00, 4'hF);
    probe(32'h8000_0010, 1, 0, 1, "R6 higher region grants");
    setRegion(4, 1, 32'h8000_0000, 6'd4, 8'h00, 4'h0);
    probe(32'h8000_0000, 0, 1, 0, "R6 higher region refuses");
    probe(32'h8000_0020, 0, 1, 1, "R6 falls to region3");
    clearFault();
  endtask

  task automatic t_runtime();
    cfgWe = 1; cfgIdx = 3'd5; cfgOn = 1; cfgBase = 32'hC000_0000;
    cfgSizeLog2 = 6'd12; cfgSliceOff = 0; cfgPerm = 4'hF;
    accValid = 1; accAddr = 32'hC000_0000; accWrite = 0; accPriv = 0;
    #1 chk("R11 same cycle old", 32'(accAllow), 0);
    tick();
    cfgWe = 0;
    chk("R11 next cycle new", 32'(accAllow), 1);
    accValid = 0;
    setRegion(5, 0, 32'hC000_0000, 6'd12, 8'h00, 4'hF);
    accAddr = 32'hC000_0000;
    #1 chk("R11 disable takes effect", 32'(accAllow), 0);
    setEnable(0);
    #1 chk("R2 disable again", 32'(accAllow), 1);
    clearFault();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_bypass();
    t_nomatch_and_fault();
    t_clear_race();
    t_size();
    t_slice();
    t_perm_prio();
    t_runtime();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all-R actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule